// File: doc/BRIEF.md
# Network Controller Command Register with Reset Sequencer

This block is the one-byte command and status register of a network controller. Software writes it to start a self-clearing soft reset and to ask the transmit and receive engines to start. Reading it returns the live state of the controller: whether a reset is still under way, whether each engine is actually running, and whether the receive ring holds no packet.

A soft reset is handled as a short sequence. Both engines are held halted. A single-cycle reinitialise pulse goes to the engines and the FIFOs, which restart their pointers. The block then waits for a done acknowledgement from each of the three parties. If not all three answer, a bounded timeout ends the wait. Only after that does the reset bit drop. The reset does not touch the address and multicast filter storage.

An enable request does not drive the engine directly. It is held as pending, and it becomes a one-cycle start pulse once the engine reports idle. The enable bits read back the engines' busy inputs, not the value that was written.

Top module: `nic_cmd_unit`

## Requirements
- R1: After the bus reset (`rst_n` low) is released, `rd_data` reads 0 in bits 7:5, 4, 2 (if `tx_busy` is low), 3 (if `rx_busy` is low) and 1. None of `tx_start`, `rx_start`, `tx_halt`, `rx_halt` or `reinit_pulse` is asserted.
- R2: `rd_data` bit 0 always equals `rx_ring_empty`.
- R3: A bus reset discards any pending enable request, so no start pulse follows it.
- R4: A write with bit 2 (transmit) or bit 3 (receive) set, while that engine is idle, gives exactly one cycle of `tx_start` or `rx_start`. The pulse appears in the second cycle after the write cycle.
- R5: `rd_data` bit 2 reads `tx_busy` and bit 3 reads `rx_busy`, whatever value was written.
- R6: An enable written while its engine is busy stays pending. The start pulse appears in the cycle after the first clock edge at which the engine is seen idle, and never while the engine is busy.
- R7: A write with the enable bit at 0 withdraws a pending request for that engine.
- R8: A write with bit 4 set, when no reset is in progress, has these effects from the next cycle: bit 4 reads 1, `tx_halt` and `rx_halt` are asserted, and `reinit_pulse` is high for exactly one cycle.
- R9: The three done inputs (`tx_done`, `rx_done`, `fifo_done`) are remembered from the reinitialise cycle onward. One cycle after the wait phase has seen all three, bit 4 and both halts drop together.
- R10: While a reset is in progress, enable writes are ignored. This includes an enable set in the same write as the reset. A reset also cancels any pending request. No start pulse is issued while halted.
- R11: If the done inputs never all arrive, bit 4 reads 1 for exactly 1+`TIMEOUT` cycles (65 by default) and then clears.
- R12: A reset write made while a reset is in progress neither restarts nor extends the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe for one cycle |
| wr_data | input | 8 | Write data: bit 4 reset, bit 3 receive enable, bit 2 transmit enable |
| rd_data | output | 8 | Read value: bit 4 reset busy, bit 3 receive active, bit 2 transmit active, bit 0 ring empty |
| tx_busy | input | 1 | Transmit engine active |
| rx_busy | input | 1 | Receive engine active |
| rx_ring_empty | input | 1 | No packet stored in the receive ring |
| tx_done | input | 1 | Transmit engine finished reinitialisation |
| rx_done | input | 1 | Receive engine finished reinitialisation |
| fifo_done | input | 1 | FIFOs finished reinitialisation |
| tx_start | output | 1 | One-cycle start request to the transmit engine |
| rx_start | output | 1 | One-cycle start request to the receive engine |
| tx_halt | output | 1 | Hold the transmit engine stopped |
| rx_halt | output | 1 | Hold the receive engine stopped |
| reinit_pulse | output | 1 | One-cycle FIFO and pointer reinitialise strobe |

## Verification
Suppose the sequencer is stuck in a wrong state. Then bit 4 or the halts stay up past the cycle after all acknowledgements arrive, or past 1+`TIMEOUT` cycles, and the fault shows within one timeout window. A lost or stale pending flag shows either as a start pulse that is missing two cycles after an idle engine is enabled, or as a pulse after a withdrawal, a reset or a bus reset. The bench watches these for several cycles after each case. A swapped or stale readback source shows in the same cycle that the engine's busy input or the ring-empty input changes.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_RST   = 4;
    localparam int BIT_RXEN  = 3;
    localparam int BIT_TXEN  = 2;
    localparam int BIT_EMPTY = 0;
    localparam int ENG_TX    = 0;
    localparam int ENG_RX    = 1;
    localparam int NUM_ENG   = 2;
    localparam int NUM_ACK   = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/nic_cmd_rst_seq.sv
module nic_cmd_rst_seq
    import nic_cmd_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int ACKS    = NUM_ACK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [ACKS-1:0] ack,
    output logic            active,
    output logic            reinit
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [ACKS-1:0] seen;
        logic [TW-1:0]   timer;
    } seq_t;

    seq_t q, d;
    logic [ACKS-1:0] seen_now;

    assign seen_now = q.seen | ack;

    always_comb begin
        d = q;
        case (q.state)
            SEQ_IDLE: begin
                if (req) begin
                    d.state = SEQ_PULSE;
                    d.seen  = '0;
                    d.timer = '0;
                end
            end
            SEQ_PULSE: begin
                d.seen  = seen_now;
                d.state = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                d.seen = seen_now;
                if (&seen_now || q.timer == T_LAST) begin
                    d.state = SEQ_IDLE;
                end else begin
                    d.timer = q.timer + 1'b1;
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, seen: '0, timer: '0};
        end else begin
            q <= d;
        end
    end

    assign active = (q.state != SEQ_IDLE);
    assign reinit = (q.state == SEQ_PULSE);
endmodule

// File: rtl/nic_cmd_eng_gate.sv
module nic_cmd_eng_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_set,
    input  logic wr_clr,
    input  logic block,
    input  logic busy,
    output logic start
);
    typedef struct packed {
        logic pend;
        logic start;
    } gate_t;

    gate_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (block) begin
            d.pend = 1'b0;
        end else begin
            if (q.pend && !busy) begin
                d.start = 1'b1;
                d.pend  = 1'b0;
            end
            if (wr_set) begin
                d.pend = 1'b1;
            end else if (wr_clr) begin
                d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pend: 1'b0, start: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start = q.start;
endmodule

// File: rtl/nic_cmd_readback.sv
module nic_cmd_readback
    import nic_cmd_pkg::*;
(
    input  logic               rst_busy,
    input  logic [NUM_ENG-1:0] eng_busy,
    input  logic               ring_empty,
    output logic [REG_W-1:0]   value
);
    always_comb begin
        value            = '0;
        value[BIT_RST]   = rst_busy;
        value[BIT_RXEN]  = eng_busy[ENG_RX];
        value[BIT_TXEN]  = eng_busy[ENG_TX];
        value[BIT_EMPTY] = ring_empty;
    end
endmodule

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
    import nic_cmd_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tx_busy,
    input  logic       rx_busy,
    input  logic       rx_ring_empty,
    input  logic       tx_done,
    input  logic       rx_done,
    input  logic       fifo_done,
    output logic       tx_start,
    output logic       rx_start,
    output logic       tx_halt,
    output logic       rx_halt,
    output logic       reinit_pulse
);
    logic               rst_req;
    logic               seq_active;
    logic               seq_reinit;
    logic               gate_block;
    logic [NUM_ENG-1:0] eng_busy;
    logic [NUM_ENG-1:0] eng_start;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[7:5], wr_data[1:0]};

    assign rst_req    = wr_en && wr_data[BIT_RST];
    assign gate_block = seq_active || rst_req;
    assign eng_busy   = {rx_busy, tx_busy};

    nic_cmd_rst_seq #(
        .TIMEOUT (TIMEOUT),
        .ACKS    (NUM_ACK)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (rst_req),
        .ack    ({fifo_done, rx_done, tx_done}),
        .active (seq_active),
        .reinit (seq_reinit)
    );

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        localparam int EN_BIT = (g == ENG_TX) ? BIT_TXEN : BIT_RXEN;
        nic_cmd_eng_gate u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_set (wr_en && wr_data[EN_BIT]),
            .wr_clr (wr_en && !wr_data[EN_BIT]),
            .block  (gate_block),
            .busy   (eng_busy[g]),
            .start  (eng_start[g])
        );
    end

    nic_cmd_readback u_rb (
        .rst_busy   (seq_active),
        .eng_busy   (eng_busy),
        .ring_empty (rx_ring_empty),
        .value      (rd_data)
    );

    assign tx_start     = eng_start[ENG_TX];
    assign rx_start     = eng_start[ENG_RX];
    assign tx_halt      = seq_active;
    assign rx_halt      = seq_active;
    assign reinit_pulse = seq_reinit;
endmodule

// File: rtl/nic_cmd_unit_chk.sv
module nic_cmd_unit_chk #(
    parameter int TIMEOUT = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic       tx_busy,
    input logic       rx_busy,
    input logic       tx_start,
    input logic       rx_start,
    input logic       tx_halt,
    input logic       rx_halt,
    input logic       reinit_pulse
);
    localparam int CW = $clog2(TIMEOUT + 3);
    localparam logic [CW-1:0] CMAX = CW'(TIMEOUT + 1);

    logic [CW-1:0] rst_cycles;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cycles <= '0;
        end else if (rd_data[4]) begin
            if (rst_cycles <= CMAX) rst_cycles <= rst_cycles + 1'b1;
        end else begin
            rst_cycles <= '0;
        end
    end

    AST_TX_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !$past(tx_busy)); // R6
    AST_RX_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |-> !$past(rx_busy)); // R6
    AST_NO_START_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_halt || rx_halt) |-> (!tx_start && !rx_start)); // R10
    AST_REINIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pulse |=> !reinit_pulse); // R8
    AST_REINIT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pulse |-> (tx_halt && rx_halt && rd_data[4])); // R8
    AST_HALT_DROP_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[4]) |-> (!tx_halt && !rx_halt && !$past(reinit_pulse))); // R9
    AST_RESET_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cycles <= CMAX); // R11
endmodule

bind nic_cmd_unit nic_cmd_unit_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_data      (rd_data),
    .tx_busy      (tx_busy),
    .rx_busy      (rx_busy),
    .tx_start     (tx_start),
    .rx_start     (rx_start),
    .tx_halt      (tx_halt),
    .rx_halt      (rx_halt),
    .reinit_pulse (reinit_pulse)
);

// File: tb/sim_nic_cmd_unit.sv
module sim_nic_cmd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 64;

    localparam logic [4:0] C_REINIT = 5'b10000;
    localparam logic [4:0] C_TXH    = 5'b01000;
    localparam logic [4:0] C_RXH    = 5'b00100;
    localparam logic [4:0] C_TXS    = 5'b00010;
    localparam logic [4:0] C_RXS    = 5'b00001;
    localparam logic [4:0] C_ALL    = 5'b11111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tx_busy = 1'b0, rx_busy = 1'b0, rx_ring_empty = 1'b1;
    logic       tx_done = 1'b0, rx_done = 1'b0, fifo_done = 1'b0;
    logic       tx_start, rx_start, tx_halt, rx_halt, reinit_pulse;

    typedef struct {
        logic [7:0] rd_exp;
        logic [7:0] rd_mask;
        logic [4:0] ctl_exp;
        logic [4:0] ctl_mask;
        string      req;
    } item_t;

    item_t sb_q[$];
    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_cmd_unit #(.TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .rx_ring_empty(rx_ring_empty), .tx_done(tx_done), .rx_done(rx_done),
        .fifo_done(fifo_done), .tx_start(tx_start), .rx_start(rx_start),
        .tx_halt(tx_halt), .rx_halt(rx_halt), .reinit_pulse(reinit_pulse)
    );

    // Expectation for the state seen after the next rising edge.
    task automatic expect_obs(input logic [7:0] re, input logic [7:0] rm,
                              input logic [4:0] ce, input logic [4:0] cm,
                              input string r);
        item_t it;
        it.rd_exp = re; it.rd_mask = rm; it.ctl_exp = ce; it.ctl_mask = cm; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
    endtask

    // Monitor: compare queued expectations after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [4:0] ctl;
                it  = sb_q.pop_front();
                ctl = {reinit_pulse, tx_halt, rx_halt, tx_start, rx_start};
                vectors++;
                if (((rd_data & it.rd_mask) != (it.rd_exp & it.rd_mask)) ||
                    ((ctl & it.ctl_mask) != (it.ctl_exp & it.ctl_mask))) begin
                    fails++;
                    $display("FAIL %s: rd=%h ctl=%b expected rd=%h/%h ctl=%b/%b",
                             it.req, rd_data, ctl, it.rd_exp, it.rd_mask,
                             it.ctl_exp, it.ctl_mask);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_obs(8'h01, 8'hFF, 5'b0, C_ALL, "R1 reset state");

        // R2 ring-empty readback
        step(); rx_ring_empty = 1'b0;
        expect_obs(8'h00, 8'h01, 5'b0, 5'b0, "R2 empty low");
        step(); rx_ring_empty = 1'b1;
        expect_obs(8'h01, 8'h01, 5'b0, 5'b0, "R2 empty high");

        // R4 / R5 transmit enable while idle
        wr(8'h04);
        expect_obs(8'h00, 8'h04, 5'b0, C_TXS, "R4 no pulse yet");
        step();
        expect_obs(8'h00, 8'h00, C_TXS, C_TXS | C_RXS, "R4 tx start pulse");
        step(); tx_busy = 1'b1;
        expect_obs(8'h04, 8'h04, 5'b0, C_TXS, "R5 tx active readback");
        step(); tx_busy = 1'b0;
        expect_obs(8'h00, 8'h04, 5'b0, C_TXS, "R5 tx idle readback");

        // R6 receive enable while busy stays pending
        step(); rx_busy = 1'b1;
        wr(8'h08);
        expect_obs(8'h08, 8'h08, 5'b0, C_RXS, "R6 pending while busy");
        for (int i = 0; i < 4; i++) begin
            step();
            expect_obs(8'h08, 8'h08, 5'b0, C_RXS, "R6 pending while busy");
        end
        step(); rx_busy = 1'b0;
        expect_obs(8'h00, 8'h08, C_RXS, C_RXS | C_TXS, "R6 start once idle");
        step(); rx_busy = 1'b1;
        expect_obs(8'h08, 8'h08, 5'b0, C_RXS, "R4 single pulse");
        step(); rx_busy = 1'b0;

        // R7 withdraw a pending request
        step(); rx_busy = 1'b1;
        wr(8'h08);
        wr(8'h00);
        step(); rx_busy = 1'b0;
        for (int i = 0; i < 4; i++) begin
            expect_obs(8'h00, 8'h00, 5'b0, C_RXS | C_TXS, "R7 withdrawn");
            step();
        end

        // R8 / R9 reset with all acknowledgements
        wr(8'h10);
        expect_obs(8'h10, 8'h10, C_REINIT | C_TXH | C_RXH, C_ALL, "R8 reset entry");
        step(); tx_done = 1'b1; rx_done = 1'b1; fifo_done = 1'b1;
        expect_obs(8'h10, 8'h10, C_TXH | C_RXH, C_ALL, "R8 single reinit");
        step(); tx_done = 1'b0; rx_done = 1'b0; fifo_done = 1'b0;
        expect_obs(8'h00, 8'h10, 5'b0, C_ALL, "R9 reset completes");

        // R10 enable writes ignored in reset, reset cancels pending
        step(); rx_busy = 1'b1;
        wr(8'h08);
        wr(8'h10);
        expect_obs(8'h10, 8'h10, 5'b0, C_RXS, "R10 in reset");
        step(); rx_busy = 1'b0; tx_done = 1'b1; rx_done = 1'b1; fifo_done = 1'b1;
        expect_obs(8'h10, 8'h10, 5'b0, C_RXS | C_TXS, "R10 no start in reset");
        wr(8'h0C); tx_done = 1'b0; rx_done = 1'b0; fifo_done = 1'b0;
        expect_obs(8'h00, 8'h10, 5'b0, C_ALL, "R9 reset completes");
        for (int i = 0; i < 4; i++) begin
            step();
            expect_obs(8'h00, 8'h00, 5'b0, C_RXS | C_TXS, "R10 ignored enables");
        end

        // R10 enable in the same write as reset
        wr(8'h1C);
        expect_obs(8'h10, 8'h10, 5'b0, C_RXS | C_TXS, "R10 combined write");
        step(); tx_done = 1'b1; rx_done = 1'b1; fifo_done = 1'b1;
        step(); tx_done = 1'b0; rx_done = 1'b0; fifo_done = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            expect_obs(8'h00, 8'h10, 5'b0, C_RXS | C_TXS, "R10 combined write");
        end

        // R11 / R12 timeout with a missing acknowledgement
        wr(8'h10);
        expect_obs(8'h10, 8'h10, C_TXH | C_RXH, C_TXH | C_RXH, "R11 timeout hold");
        step(); tx_done = 1'b1; rx_done = 1'b1;
        expect_obs(8'h10, 8'h10, 5'b0, 5'b0, "R11 timeout hold");
        for (int e = 3; e <= TMO + 1; e++) begin
            if (e == 30) begin
                wr(8'h10);
                expect_obs(8'h10, 8'h10, 5'b0, C_REINIT, "R12 no restart");
            end else begin
                step();
                expect_obs(8'h10, 8'h10, 5'b0, 5'b0, "R11 timeout hold");
            end
            tx_done = 1'b0; rx_done = 1'b0;
        end
        step();
        expect_obs(8'h00, 8'h10, 5'b0, C_TXH | C_RXH, "R11 R12 timeout end");

        // R3 bus reset drops a pending request
        step(); rx_busy = 1'b1;
        wr(8'h08);
        step(); rst_n = 1'b0;
        step(); rst_n = 1'b1; rx_busy = 1'b0;
        for (int i = 0; i < 4; i++) begin
            expect_obs(8'h01, 8'hFF, 5'b0, C_ALL, "R3 R1 after bus reset");
            step();
        end

        repeat (3) step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule